// File: doc/BRIEF.md
# Per-Processor Interrupt Presentation Unit

This unit is the presentation stage between a shared interrupt source controller and a single processor. It has one pending slot. The slot holds the source number of the interrupt that is currently offered to the processor, together with that interrupt's priority. The source controller offers interrupts as a source number plus a priority. Each offer either wins the slot or is bounced back to its source with a reject strobe, so that the source can offer it again later. A winning offer that displaces an interrupt already in the slot also bounces the loser. Inter-processor interrupts compete for the same slot under a fixed source number, using their own priority register.

The processor controls the unit through five operations:
- accept: takes the pending interrupt.
- end-of-interrupt: restores the processor priority and signals completion to the source.
- set processor priority.
- set IPI priority.
- poll: reads state without side effects.

All requests to the source side are single-cycle strobes: reject, completion and resend. Priorities are 8 bits wide, and a smaller value is more favoured. All-ones means "none". An operation and an offer never arrive in the same cycle. The surrounding fabric serialises them.

Top module: `intr_presenter`

## Requirements
- R1: After reset the presentation word (processor priority in bits 31:24, pending source in bits 23:0) reads zero. The pending priority and the IPI priority are 0xFF, and `irq_o` is low.
- R2: An offer is bounced with a reject strobe carrying the offered source when its priority is not below the processor priority. It is also bounced when a source is pending whose priority is less than or equal to the offered one. In both cases the slot is unchanged.
- R3: An offer that is not bounced replaces the slot contents with its source and priority, and raises `irq_o`. A source that was already pending is bounced with a reject strobe.
- R4: Accept (op code 0) returns the presentation word as it was before the operation. It loads the processor priority with the pending priority, empties the slot, sets the pending priority to 0xFF and drops `irq_o`.
- R5: Poll (op code 4) returns the presentation word and the IPI priority, and changes no state.
- R6: Set IPI priority (op code 3, value in bits 7:0) stores the value. When the value is below the processor priority, an IPI check is run. The check does nothing if a source is pending whose priority is less than or equal to the IPI priority. Otherwise it bounces any pending source, loads source number 2 with the IPI priority, and raises `irq_o`.
- R7: Set processor priority (op code 2, value in bits 7:0) stores the value. If the value is lower than before, a source is pending, and the value is less than or equal to the pending priority, then the slot is emptied, the pending priority becomes 0xFF, `irq_o` drops and the old source is bounced.
- R8: A processor-priority write that does not lower the priority, made while the slot is empty, triggers a resend. The resend first runs the IPI check when the IPI priority is below the new processor priority, and then pulses `resend_o`.
- R9: End-of-interrupt (op code 1) copies data bits 31:24 into the processor priority and pulses `eoi_o` with data bits 23:0 as the source. If the slot is empty, a resend as in R8 follows.
- R10: Reject, completion, resend and read-valid outputs rise in the cycle after the request that causes them, and fall again one cycle later unless a new request causes them.
- R11: `irq_o` is high exactly when the pending source is nonzero.
- R12: Op codes 5, 6 and 7 change no state and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| offer_valid_i | input | 1 | Offer strobe from the source controller |
| offer_src_i | input | 24 | Offered source number (nonzero) |
| offer_prio_i | input | 8 | Offered priority |
| op_valid_i | input | 1 | Processor operation strobe |
| op_code_i | input | 3 | Operation code |
| op_data_i | input | 32 | Operation data word |
| irq_o | output | 1 | Interrupt request to the processor |
| rd_valid_o | output | 1 | Read data valid after accept or poll |
| rd_word_o | output | 32 | Presentation word returned |
| rd_ipi_prio_o | output | 8 | IPI priority returned |
| reject_o | output | 1 | Bounce strobe to the source controller |
| reject_src_o | output | 24 | Bounced source number |
| eoi_o | output | 1 | Completion strobe to the source controller |
| eoi_src_o | output | 24 | Completed source number |
| resend_o | output | 1 | Resend request strobe |

## Verification
The bench sweeps every offer priority in descending order against several processor priorities, so that every offer displaces the previous one. A design that used a strict comparison where the rule is "less than or equal" would keep the wrong source on a tie, or bounce no loser at all. IPI priorities are swept in the same way, to catch an IPI check that ignores the pending priority or fails to bounce the displaced source. Processor-priority writes are swept across a fixed pending interrupt, to expose an off-by-one in the lowering rule or a resend issued while the slot is full. A long pseudo-random mix with frequent priority ties checks ordering faults: evaluating the resend IPI check against the old processor priority instead of the new one, or returning the presentation word after accept has cleared it.

// File: rtl/intr_presenter_pkg.sv
package intr_presenter_pkg;
  typedef enum logic [2:0] {
    OP_ACCEPT   = 3'd0,
    OP_EOI      = 3'd1,
    OP_SET_CPPR = 3'd2,
    OP_SET_IPI  = 3'd3,
    OP_POLL     = 3'd4
  } ip_op_e;
endpackage

// File: rtl/ip_prio_cmp.sv
module ip_prio_cmp #(
  parameter int unsigned PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] cand_i,
  input  logic [PRIO_W-1:0] ref_i,
  input  logic              busy_i,
  input  logic [PRIO_W-1:0] pend_i,
  output logic              below_o,
  output logic              beats_o
);
  assign below_o = cand_i < ref_i;
  // a tie leaves the current holder in place
  assign beats_o = !busy_i || (cand_i < pend_i);
endmodule

// File: rtl/ip_pulse.sv
module ip_pulse #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         fire_i,
  input  logic [W-1:0] data_i,
  output logic         pulse_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o <= 1'b0;
      data_o  <= '0;
    end else begin
      pulse_o <= fire_i;
      if (fire_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import intr_presenter_pkg::*;
#(
  parameter int unsigned SRC_W   = 24,
  parameter int unsigned PRIO_W  = 8,
  parameter int unsigned IPI_SRC = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    offer_valid_i,
  input  logic [SRC_W-1:0]        offer_src_i,
  input  logic [PRIO_W-1:0]       offer_prio_i,
  input  logic                    op_valid_i,
  input  logic [2:0]              op_code_i,
  input  logic [PRIO_W+SRC_W-1:0] op_data_i,
  output logic                    irq_o,
  output logic                    rd_valid_o,
  output logic [PRIO_W+SRC_W-1:0] rd_word_o,
  output logic [PRIO_W-1:0]       rd_ipi_prio_o,
  output logic                    reject_o,
  output logic [SRC_W-1:0]        reject_src_o,
  output logic                    eoi_o,
  output logic [SRC_W-1:0]        eoi_src_o,
  output logic                    resend_o
);
  localparam int unsigned WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
  localparam logic [SRC_W-1:0]  IPI_NUM   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] cppr_q, cppr_n, pend_q, pend_n, mfrr_q, mfrr_n;
  logic [SRC_W-1:0]  xisr_q, xisr_n;
  logic              irq_q, irq_n;
  logic              busy;

  logic [PRIO_W-1:0] cppr_eff, ipi_cand;
  logic              offer_below, offer_beats, ipi_below, ipi_beats;
  logic              do_ipi, rej_fire, eoi_fire, resend_n, rd_n;
  logic [SRC_W-1:0]  rej_src;
  ip_op_e            op;

  assign busy = |xisr_q;
  assign op   = ip_op_e'(op_code_i);

  // candidate values seen by the IPI check: new CPPR, new or stored IPI prio
  always_comb begin
    cppr_eff = cppr_q;
    ipi_cand = mfrr_q;
    if (op_valid_i) begin
      case (op)
        OP_SET_CPPR: cppr_eff = op_data_i[PRIO_W-1:0];
        OP_EOI:      cppr_eff = op_data_i[WORD_W-1:SRC_W];
        OP_SET_IPI:  ipi_cand = op_data_i[PRIO_W-1:0];
        default: ;
      endcase
    end
  end

  ip_prio_cmp #(.PRIO_W(PRIO_W)) u_offer_cmp (
    .cand_i (offer_prio_i),
    .ref_i  (cppr_q),
    .busy_i (busy),
    .pend_i (pend_q),
    .below_o(offer_below),
    .beats_o(offer_beats)
  );

  ip_prio_cmp #(.PRIO_W(PRIO_W)) u_ipi_cmp (
    .cand_i (ipi_cand),
    .ref_i  (cppr_eff),
    .busy_i (busy),
    .pend_i (pend_q),
    .below_o(ipi_below),
    .beats_o(ipi_beats)
  );

  always_comb begin
    cppr_n   = cppr_q;
    xisr_n   = xisr_q;
    pend_n   = pend_q;
    mfrr_n   = mfrr_q;
    irq_n    = irq_q;
    rej_fire = 1'b0;
    rej_src  = xisr_q;
    eoi_fire = 1'b0;
    resend_n = 1'b0;
    rd_n     = 1'b0;
    do_ipi   = 1'b0;
    if (op_valid_i) begin
      case (op)
        OP_ACCEPT: begin
          rd_n   = 1'b1;
          cppr_n = pend_q;
          xisr_n = '0;
          pend_n = PRIO_NONE;
          irq_n  = 1'b0;
        end
        OP_POLL: rd_n = 1'b1;
        OP_SET_IPI: begin
          mfrr_n = ipi_cand;
          do_ipi = ipi_below;
        end
        OP_SET_CPPR: begin
          cppr_n = cppr_eff;
          if (cppr_eff < cppr_q) begin
            if (busy && (cppr_eff <= pend_q)) begin
              rej_fire = 1'b1;
              xisr_n   = '0;
              pend_n   = PRIO_NONE;
              irq_n    = 1'b0;
            end
          end else if (!busy) begin
            resend_n = 1'b1;
            do_ipi   = ipi_below;
          end
        end
        OP_EOI: begin
          cppr_n   = cppr_eff;
          eoi_fire = 1'b1;
          if (!busy) begin
            resend_n = 1'b1;
            do_ipi   = ipi_below;
          end
        end
        default: ;
      endcase
    end else if (offer_valid_i) begin
      if (offer_below && offer_beats) begin
        rej_fire = busy;
        xisr_n   = offer_src_i;
        pend_n   = offer_prio_i;
        irq_n    = 1'b1;
      end else begin
        rej_fire = 1'b1;
        rej_src  = offer_src_i;
      end
    end
    if (do_ipi && ipi_beats) begin
      if (busy) rej_fire = 1'b1;
      xisr_n = IPI_NUM;
      pend_n = ipi_cand;
      irq_n  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cppr_q        <= '0;
      xisr_q        <= '0;
      pend_q        <= PRIO_NONE;
      mfrr_q        <= PRIO_NONE;
      irq_q         <= 1'b0;
      resend_o      <= 1'b0;
      rd_valid_o    <= 1'b0;
      rd_word_o     <= '0;
      rd_ipi_prio_o <= PRIO_NONE;
    end else begin
      cppr_q     <= cppr_n;
      xisr_q     <= xisr_n;
      pend_q     <= pend_n;
      mfrr_q     <= mfrr_n;
      irq_q      <= irq_n;
      resend_o   <= resend_n;
      rd_valid_o <= rd_n;
      if (rd_n) begin
        rd_word_o     <= {cppr_q, xisr_q};
        rd_ipi_prio_o <= mfrr_q;
      end
    end
  end

  assign irq_o = irq_q;

  ip_pulse #(.W(SRC_W)) u_reject (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (rej_fire),
    .data_i (rej_src),
    .pulse_o(reject_o),
    .data_o (reject_src_o)
  );

  ip_pulse #(.W(SRC_W)) u_eoi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (eoi_fire),
    .data_i (op_data_i[SRC_W-1:0]),
    .pulse_o(eoi_o),
    .data_o (eoi_src_o)
  );

  // interface contract: operations and offers are serialised upstream
  p_no_collision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(offer_valid_i && op_valid_i));

  p_irq_tracks_slot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (xisr_q != '0));

  p_offer_bounce_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offer_valid_i && !op_valid_i && offer_prio_i >= cppr_q)
    |=> (reject_o && reject_src_o == $past(offer_src_i)));

  p_accept_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_ACCEPT)
    |=> (xisr_q == '0 && pend_q == PRIO_NONE && !irq_o && rd_valid_o));

  p_poll_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_POLL)
    |=> ($stable(cppr_q) && $stable(xisr_q) && $stable(pend_q) && $stable(mfrr_q)));

  p_ipi_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_SET_IPI && xisr_q == '0
     && op_data_i[PRIO_W-1:0] < cppr_q)
    |=> (xisr_q == IPI_NUM && irq_o));

  p_eoi_strobe_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_EOI)
    |=> (eoi_o && cppr_q == $past(op_data_i[WORD_W-1:SRC_W])));

endmodule

// File: tb/tb_intr_presenter.sv
module tb_intr_presenter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ov = 1'b0;
  logic [23:0] osrc = '0;
  logic [7:0]  oprio = '0;
  logic        pv = 1'b0;
  logic [2:0]  pcode = '0;
  logic [31:0] pdata = '0;

  logic        irq, rd_valid, rej, eoi, resend;
  logic [31:0] rd_word;
  logic [7:0]  rd_ipi;
  logic [23:0] rej_src, eoi_src;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  intr_presenter dut (
    .clk_i(clk), .rst_ni(rst_n),
    .offer_valid_i(ov), .offer_src_i(osrc), .offer_prio_i(oprio),
    .op_valid_i(pv), .op_code_i(pcode), .op_data_i(pdata),
    .irq_o(irq), .rd_valid_o(rd_valid), .rd_word_o(rd_word),
    .rd_ipi_prio_o(rd_ipi), .reject_o(rej), .reject_src_o(rej_src),
    .eoi_o(eoi), .eoi_src_o(eoi_src), .resend_o(resend)
  );

  // reference state
  logic [7:0]  m_cppr = 8'h00, m_pend = 8'hFF, m_mfrr = 8'hFF;
  logic [23:0] m_xisr = '0;
  logic        e_rej, e_eoi, e_res, e_rd;
  logic [23:0] e_rej_src, e_eoi_src;
  logic [31:0] e_word;
  logic [7:0]  e_ipi;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_ipi(input logic [7:0] cand);
    if (m_xisr != 0 && m_pend <= cand) return;
    if (m_xisr != 0) begin e_rej = 1; e_rej_src = m_xisr; end
    m_xisr = 24'd2;
    m_pend = cand;
  endtask

  task automatic m_resend();
    if (m_mfrr < m_cppr) m_ipi(m_mfrr);
    e_res = 1;
  endtask

  task automatic step(input bit do_off, input logic [23:0] s, input logic [7:0] p,
                      input bit do_op, input logic [2:0] code, input logic [31:0] d);
    string tag;
    logic [7:0] old;
    e_rej = 0; e_eoi = 0; e_res = 0; e_rd = 0;
    e_rej_src = '0; e_eoi_src = '0; e_word = '0; e_ipi = '0;
    tag = "R10 idle";
    if (do_op) begin
      case (code)
        3'd0: begin
          tag = "R4 accept";
          e_rd = 1; e_word = {m_cppr, m_xisr}; e_ipi = m_mfrr;
          m_cppr = m_pend; m_xisr = 0; m_pend = 8'hFF;
        end
        3'd1: begin
          tag = "R9 eoi";
          m_cppr = d[31:24]; e_eoi = 1; e_eoi_src = d[23:0];
          if (m_xisr == 0) m_resend();
        end
        3'd2: begin
          old = m_cppr; m_cppr = d[7:0];
          if (d[7:0] < old) begin
            tag = "R7 lower cppr";
            if (m_xisr != 0 && d[7:0] <= m_pend) begin
              e_rej = 1; e_rej_src = m_xisr; m_xisr = 0; m_pend = 8'hFF;
            end
          end else begin
            tag = "R8 raise cppr";
            if (m_xisr == 0) m_resend();
          end
        end
        3'd3: begin
          tag = "R6 set ipi";
          m_mfrr = d[7:0];
          if (d[7:0] < m_cppr) m_ipi(d[7:0]);
        end
        3'd4: begin
          tag = "R5 poll";
          e_rd = 1; e_word = {m_cppr, m_xisr}; e_ipi = m_mfrr;
        end
        default: tag = "R12 bad op";
      endcase
    end else if (do_off) begin
      if (p >= m_cppr || (m_xisr != 0 && m_pend <= p)) begin
        tag = "R2 offer bounce";
        e_rej = 1; e_rej_src = s;
      end else begin
        tag = "R3 offer win";
        if (m_xisr != 0) begin e_rej = 1; e_rej_src = m_xisr; end
        m_xisr = s; m_pend = p;
      end
    end
    @(negedge clk);
    ov = do_off; osrc = s; oprio = p;
    pv = do_op; pcode = code; pdata = d;
    @(posedge clk);
    #1;
    ov = 0; pv = 0;
    chk({tag, " reject"}, {31'd0, rej}, {31'd0, e_rej});
    if (e_rej) chk({tag, " reject src"}, {8'd0, rej_src}, {8'd0, e_rej_src});
    chk({tag, " eoi"}, {31'd0, eoi}, {31'd0, e_eoi});
    if (e_eoi) chk({tag, " eoi src"}, {8'd0, eoi_src}, {8'd0, e_eoi_src});
    chk({tag, " resend"}, {31'd0, resend}, {31'd0, e_res});
    chk({tag, " rd_valid"}, {31'd0, rd_valid}, {31'd0, e_rd});
    if (e_rd) begin
      chk({tag, " word"}, rd_word, e_word);
      chk({tag, " ipi prio"}, {24'd0, rd_ipi}, {24'd0, e_ipi});
    end
    chk({tag, " R11 irq"}, {31'd0, irq}, {31'd0, (m_xisr != 0)});
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] x;
    logic [7:0]  cs [3];
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 reject after reset", {31'd0, rej}, 32'd0);
    rst_n = 1'b1;
    step(0, 0, 0, 1, 3'd4, 0);
    chk("R1 word after reset", rd_word, 32'd0);
    chk("R1 ipi after reset", {24'd0, rd_ipi}, 32'h0000_00FF);

    // descending offer sweep: each winner displaces the previous holder
    cs[0] = 8'h00; cs[1] = 8'h40; cs[2] = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      step(0, 0, 0, 1, 3'd2, {24'd0, cs[i]});
      for (int k = 255; k >= 0; k--)
        step(1, 24'h1000 + 24'(k), 8'(k), 0, 0, 0);
      step(1, 24'h2222, 8'h00, 0, 0, 0);
      step(0, 0, 0, 1, 3'd0, 0);
      step(0, 0, 0, 1, 3'd1, {cs[i], 24'h1000});
      step(0, 0, 0, 1, 3'd4, 0);
    end

    // IPI priority sweep against two processor priorities
    cs[0] = 8'h10; cs[1] = 8'h80;
    for (int i = 0; i < 2; i++) begin
      step(0, 0, 0, 1, 3'd2, {24'd0, cs[i]});
      step(1, 24'h3333, 8'h08, 0, 0, 0);
      for (int v = 255; v >= 0; v--)
        step(0, 0, 0, 1, 3'd3, 32'(v));
      step(0, 0, 0, 1, 3'd0, 0);
      step(0, 0, 0, 1, 3'd1, {8'hFF, 24'd2});
      step(0, 0, 0, 1, 3'd3, 32'h0000_00FF);
    end

    // processor-priority writes across a pending interrupt
    for (int q = 0; q < 256; q += 5) begin
      step(0, 0, 0, 1, 3'd2, 32'h0000_00FF);
      step(1, 24'h4444, 8'h80, 0, 0, 0);
      step(0, 0, 0, 1, 3'd2, 32'(q));
      step(0, 0, 0, 1, 3'd4, 0);
      step(0, 0, 0, 0, 0, 0);
    end

    // pseudo-random mix with frequent priority ties
    x = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] pr;
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      pr = (x[7:4] == 4'hF) ? 8'hFF : {x[6:4], 5'd0};
      case (x[11:8])
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4: step(1, 24'h100 + 24'(x[23:12]), pr, 0, 0, 0);
        4'd5: step(0, 0, 0, 1, 3'd0, 0);
        4'd6: step(0, 0, 0, 1, 3'd1, {pr, 24'h100 + 24'(x[23:12])});
        4'd7, 4'd8: step(0, 0, 0, 1, 3'd2, {24'd0, pr});
        4'd9: step(0, 0, 0, 1, 3'd3, {24'd0, pr});
        4'd10: step(0, 0, 0, 1, 3'd4, 0);
        4'd11: step(0, 0, 0, 1, 3'd5 + 3'(x[13:12] % 3), x);
        default: step(0, 0, 0, 0, 0, 0);
      endcase
    end
    step(0, 0, 0, 1, 3'd7, 32'hFFFF_FFFF);
    step(0, 0, 0, 1, 3'd4, 0);
    summary();
    $finish;
  end
endmodule